// File: doc/BRIEF.md
# Stereo Attenuation Register File with Sample-Aligned Update

This block keeps the left and right attenuation settings of a stereo audio output path. Each channel uses a 10-bit attenuation code. A register write port carries an address and a data word. Each code is split across two 5-bit registers: one holds the fine half and the other holds the coarse half. A write lands only in a holding stage. The new settings become active only when a write asks for an update, and then only on the next input-sample strobe. Because of this, a full 10-bit code changes on one sample boundary and never half-way through.

The block has one control register with a tracking bit. When the tracking bit is set, the right output takes the active left setting. The right channel's own stored setting is left untouched, and clearing the bit brings that setting back. The block drives the effective left and right codes and a mute flag for each channel. Code 0 means 0 dB. Each step of the low five bits is 0.125 dB and each step of the high five bits is 4 dB. The all-ones code means full mute.

Top module: `stereo_atten_regs`

## Requirements
- R1: Write address 0 sets left code bits [4:0] and address 1 sets left bits [9:5]. Address 2 sets right bits [4:0] and address 3 sets right bits [9:5]. The value comes from data bits [4:0], and data bit 5 is the update flag.
- R2: A write to addresses 0 to 3 with the update flag at 0 changes only the holding stage, and neither output code changes.
- R3: A write to addresses 0 to 3 with the update flag at 1 makes all held fields, together with the field being written, active at the next sample strobe. This includes a strobe in the same cycle as the write.
- R4: A requested update stays pending until a sample strobe arrives. The output codes change only on clock edges where the sample strobe is high, and a strobe with no pending or current update leaves them unchanged.
- R5: A channel's mute output is 1 exactly when that channel's effective code is 3FFh.
- R6: Address 4 data bit 2 is the tracking bit. When it is 1, the right output equals the active left code, starting at the next sample strobe, with no update write needed.
- R7: Tracking never changes the stored right fields. Clearing the tracking bit brings back the right channel's own active code at the next sample strobe.
- R8: Writes to addresses 5 to 7 are ignored, including their update flag.
- R9: While rst_ni is low, all held fields, all active codes and the tracking bit are 0, so both outputs are 0 and both mute flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 6 | Write data: [4:0] value, [5] update flag, bit 2 tracking at address 4 |
| sample_i | input | 1 | Input-sample strobe |
| left_code_o | output | 10 | Effective left attenuation code |
| right_code_o | output | 10 | Effective right attenuation code |
| left_mute_o | output | 1 | Left channel muted |
| right_mute_o | output | 1 | Right channel muted |

## Verification
The hardest state to reach from the ports is one where the holding stage differs from the active codes while an update is, or is not, still pending. In that state a stray strobe, or a write to an undefined address, would expose a wrong transfer. The stimulus table builds this state on purpose. It writes fields without the update flag, then sends strobes with no update, and sends writes to undefined addresses that carry the flag. Only after that does it trigger a transfer. In other cases the request is armed several cycles before a strobe arrives. Tracking is switched on and off around right-channel updates, so the bench shows that the stored right code survives while it is hidden.

// File: rtl/stereo_atten_pkg.sv
package stereo_atten_pkg;
  localparam int unsigned FIELD_W    = 5;
  localparam int unsigned CODE_W     = 2 * FIELD_W;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned NUM_FIELDS = 2 * NUM_CH;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned UPD_BIT    = FIELD_W;
  localparam int unsigned DATA_W     = UPD_BIT + 1;
  localparam int unsigned TRK_BIT    = 2;
  localparam logic [ADDR_W-1:0] TRK_ADDR = ADDR_W'(NUM_FIELDS);

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [CODE_W-1:0]  code_t;

  localparam code_t MUTE_CODE = '1;
endpackage

// File: rtl/atten_prelatch.sv
module atten_prelatch
  import stereo_atten_pkg::*;
(
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   wr_addr_i,
  input  logic [DATA_W-1:0]                   wr_data_i,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  pl_nxt_o,
  output logic                                trk_nxt_o
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] pl_q;
  logic trk_q;
  logic trk_hit;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    logic hit;
    assign hit         = wr_en_i && (wr_addr_i == ADDR_W'(f));
    assign pl_nxt_o[f] = hit ? wr_data_i[FIELD_W-1:0] : pl_q[f];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pl_q[f] <= '0;
      else         pl_q[f] <= pl_nxt_o[f];
    end
  end

  assign trk_hit   = wr_en_i && (wr_addr_i == TRK_ADDR);
  assign trk_nxt_o = trk_hit ? wr_data_i[TRK_BIT] : trk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trk_q <= 1'b0;
    else         trk_q <= trk_nxt_o;
  end
endmodule

// File: rtl/atten_upd_ctrl.sv
module atten_upd_ctrl
  import stereo_atten_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sample_i,
  output logic              take_o,
  output logic              pend_o
);
  logic in_range;
  logic upd_now;
  logic pend_q;

  assign in_range = wr_addr_i < ADDR_W'(NUM_FIELDS);
  assign upd_now  = wr_en_i && in_range && wr_data_i[UPD_BIT];
  assign take_o   = sample_i && (pend_q || upd_now);
  assign pend_o   = pend_q;

  // request stays armed until a strobe consumes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (sample_i) pend_q <= 1'b0;
    else if (upd_now)  pend_q <= 1'b1;
  end
endmodule

// File: rtl/atten_active.sv
module atten_active
  import stereo_atten_pkg::*;
(
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               sample_i,
  input  logic                               take_i,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] pl_nxt_i,
  input  logic                               trk_nxt_i,
  output logic [NUM_CH-1:0][CODE_W-1:0]      code_o,
  output logic [NUM_CH-1:0]                  mute_o
);
  logic [NUM_CH-1:0][CODE_W-1:0] act_q;
  logic trk_act_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     act_q[c] <= '0;
      else if (take_i) act_q[c] <= {pl_nxt_i[2*c+1], pl_nxt_i[2*c]};
    end

    // channel 0 is left; all others follow it while tracking
    if (c == 0) begin : g_src
      assign code_o[c] = act_q[c];
    end else begin : g_trk
      assign code_o[c] = trk_act_q ? act_q[0] : act_q[c];
    end

    assign mute_o[c] = (code_o[c] == MUTE_CODE);
  end

  // tracking applies at any strobe, no update needed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       trk_act_q <= 1'b0;
    else if (sample_i) trk_act_q <= trk_nxt_i;
  end
endmodule

// File: rtl/stereo_atten_regs.sv
module stereo_atten_regs
  import stereo_atten_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sample_i,
  output logic [CODE_W-1:0] left_code_o,
  output logic [CODE_W-1:0] right_code_o,
  output logic              left_mute_o,
  output logic              right_mute_o
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] pl_nxt;
  logic                               trk_nxt;
  logic                               take;
  logic                               upd_pend;
  logic [NUM_CH-1:0][CODE_W-1:0]      code;
  logic [NUM_CH-1:0]                  mute;

  atten_prelatch u_prelatch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pl_nxt_o  (pl_nxt),
    .trk_nxt_o (trk_nxt)
  );

  atten_upd_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sample_i  (sample_i),
    .take_o    (take),
    .pend_o    (upd_pend)
  );

  atten_active u_active (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_i),
    .take_i    (take),
    .pl_nxt_i  (pl_nxt),
    .trk_nxt_i (trk_nxt),
    .code_o    (code),
    .mute_o    (mute)
  );

  assign left_code_o  = code[0];
  assign right_code_o = code[1];
  assign left_mute_o  = mute[0];
  assign right_mute_o = mute[1];
endmodule

// File: rtl/stereo_atten_regs_chk.sv
module stereo_atten_regs_chk
  import stereo_atten_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              sample_i,
  input logic [CODE_W-1:0] left_code_o,
  input logic [CODE_W-1:0] right_code_o,
  input logic              left_mute_o,
  input logic              right_mute_o,
  input logic              pend_i
);
  // R4
  hold_between_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> ($stable(left_code_o) && $stable(right_code_o)));

  // R2
  no_upd_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !pend_i && wr_en_i && (wr_addr_i < ADDR_W'(NUM_FIELDS)) && !wr_data_i[UPD_BIT])
      |=> ($stable(left_code_o) && $stable(right_code_o)));

  // R5
  mute_rise_on_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(left_mute_o) || $rose(right_mute_o)) |-> $past(sample_i));

  // R6
  track_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && wr_en_i && (wr_addr_i == TRK_ADDR) && wr_data_i[TRK_BIT])
      |=> (right_code_o == left_code_o));

  // R9
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (left_code_o == '0 && right_code_o == '0 &&
                               !left_mute_o && !right_mute_o);
    end
  end
endmodule

bind stereo_atten_regs stereo_atten_regs_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .sample_i     (sample_i),
  .left_code_o  (left_code_o),
  .right_code_o (right_code_o),
  .left_mute_o  (left_mute_o),
  .right_mute_o (right_mute_o),
  .pend_i       (upd_pend)
);

// File: tb/stereo_atten_regs_tb.sv
`timescale 1ns/1ps
module stereo_atten_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [5:0] data = '0;
  logic       strb = 1'b0;
  logic [9:0] l_code, r_code;
  logic       l_mute, r_mute;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  stereo_atten_regs u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (we),
    .wr_addr_i    (addr),
    .wr_data_i    (data),
    .sample_i     (strb),
    .left_code_o  (l_code),
    .right_code_o (r_code),
    .left_mute_o  (l_mute),
    .right_mute_o (r_mute)
  );

  // {we, addr[2:0], upd, val[4:0], strobe, exp_left[9:0], exp_right[9:0]}
  localparam int NV = 20;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 3'd0, 1'b0, 5'h05, 1'b0, 10'h000, 10'h000}, // R2 R1
    {1'b1, 3'd1, 1'b0, 5'h02, 1'b1, 10'h000, 10'h000}, // R4 strobe, nothing pending
    {1'b1, 3'd1, 1'b1, 5'h02, 1'b0, 10'h000, 10'h000}, // R4 arm
    {1'b0, 3'd0, 1'b0, 5'h00, 1'b0, 10'h000, 10'h000}, // R4 still armed
    {1'b0, 3'd0, 1'b0, 5'h00, 1'b1, 10'h045, 10'h000}, // R3 transfer
    {1'b1, 3'd2, 1'b0, 5'h1F, 1'b0, 10'h045, 10'h000}, // R2
    {1'b1, 3'd3, 1'b1, 5'h1F, 1'b1, 10'h045, 10'h3FF}, // R3 same-cycle, R5
    {1'b1, 3'd4, 1'b0, 5'h04, 1'b0, 10'h045, 10'h3FF}, // R6 waits for strobe
    {1'b0, 3'd0, 1'b0, 5'h00, 1'b1, 10'h045, 10'h045}, // R6
    {1'b1, 3'd0, 1'b1, 5'h1F, 1'b1, 10'h05F, 10'h05F}, // R6 follows new left
    {1'b1, 3'd4, 1'b0, 5'h00, 1'b1, 10'h05F, 10'h3FF}, // R7 restore
    {1'b1, 3'd0, 1'b0, 5'h00, 1'b0, 10'h05F, 10'h3FF}, // R2
    {1'b1, 3'd5, 1'b1, 5'h00, 1'b1, 10'h05F, 10'h3FF}, // R8
    {1'b1, 3'd7, 1'b1, 5'h1F, 1'b1, 10'h05F, 10'h3FF}, // R8
    {1'b1, 3'd1, 1'b1, 5'h1F, 1'b1, 10'h3E0, 10'h3FF}, // R1 R3
    {1'b1, 3'd0, 1'b1, 5'h1F, 1'b0, 10'h3E0, 10'h3FF}, // R4 arm
    {1'b1, 3'd6, 1'b0, 5'h00, 1'b1, 10'h3FF, 10'h3FF}, // R4 R5 R8
    {1'b1, 3'd4, 1'b0, 5'h04, 1'b1, 10'h3FF, 10'h3FF}, // R6
    {1'b1, 3'd2, 1'b1, 5'h00, 1'b1, 10'h3FF, 10'h3FF}, // R7 hidden right update
    {1'b1, 3'd4, 1'b0, 5'h00, 1'b1, 10'h3FF, 10'h3E0}  // R7
  };
  localparam string VREQ [NV] = '{
    "R2", "R4", "R4", "R4", "R3", "R2", "R3", "R6", "R6", "R6",
    "R7", "R2", "R8", "R8", "R1", "R4", "R4", "R6", "R7", "R7"
  };

  task automatic check_out(input string req, input logic [9:0] el, input logic [9:0] er);
    logic em_l, em_r;
    em_l = (el == 10'h3FF);
    em_r = (er == 10'h3FF);
    checks++;
    if (l_code !== el || r_code !== er || l_mute !== em_l || r_mute !== em_r) begin
      fails++;
      $display("FAIL %s: got L=%h R=%h lm=%b rm=%b, expected L=%h R=%h lm=%b rm=%b",
               req, l_code, r_code, l_mute, r_mute, el, er, em_l, em_r);
    end
  endtask

  task automatic cycle(input logic w, input logic [2:0] a, input logic u,
                       input logic [4:0] v, input logic s);
    @(negedge clk);
    we = w; addr = a; data = {u, v}; strb = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check_out("R9", 10'h000, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [30:0] e;
      e = VEC[i];
      cycle(e[30], e[29:27], e[26], e[25:21], e[20]);
      check_out(VREQ[i], e[19:10], e[9:0]);
    end

    // R9: reset in mid-run clears active and held state
    @(negedge clk);
    we = 1'b0; strb = 1'b0;
    rst_n = 1'b0;
    #1;
    check_out("R9", 10'h000, 10'h000);
    @(negedge clk);
    rst_n = 1'b1;
    // R9: held fields were cleared too, so an update brings out only the new field
    cycle(1'b1, 3'd3, 1'b1, 5'h01, 1'b1);
    check_out("R9", 10'h000, 10'h020);
    // R9: tracking bit cleared by reset; strobe keeps right separate
    cycle(1'b0, 3'd0, 1'b0, 5'h00, 1'b1);
    check_out("R9", 10'h000, 10'h020);
    // R1: left low field alone, update same cycle
    cycle(1'b1, 3'd0, 1'b1, 5'h1E, 1'b1);
    check_out("R1", 10'h01E, 10'h020);
    // R5: 3FEh is not mute
    cycle(1'b1, 3'd1, 1'b1, 5'h1F, 1'b1);
    check_out("R5", 10'h3FE, 10'h020);
    // R4: outputs hold across idle cycles
    for (int k = 0; k < 3; k++) begin
      cycle(1'b1, 3'd0, 1'b0, 5'h1F, 1'b0);
      check_out("R4", 10'h3FE, 10'h020);
    end
    // R3: held low field from earlier writes becomes active with upd on right
    cycle(1'b1, 3'd2, 1'b1, 5'h00, 1'b1);
    check_out("R3", 10'h3FF, 10'h020);

    @(negedge clk);
    we = 1'b0; strb = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule